// File: doc/BRIEF.md
# Planar Video Memory Access Unit

This block sits between a host byte port and a four-plane video memory. Each plane holds 8-bit values, and the memory stores one byte of every plane per 32-bit word. Plane p occupies bits 8p+7..8p of the word. The host presents a 17-bit byte offset into a 128 KiB window. The block checks that offset against the selected memory-map mode and then translates the access in one of three ways:

- **Chain-4:** the offset addresses a single byte directly.
- **Odd/even:** the offset is interleaved across a pair of planes.
- **Planar:** every plane is touched at once through a 32-bit latch.

Control values arrive as plain register inputs. They are held stable from the start of an access until its response.

A planar read loads the latch and returns either one plane's byte or a colour-compare result. A planar write builds a 32-bit word through a fixed sequence of steps:

1. The host byte is rotated.
2. The set/reset fill is applied.
3. An ALU combines the data with the latch.
4. A bit mask merges the result with the latch.

The memory's byte enables then carry the plane write mask. Because the memory has per-byte enables, every write is one memory cycle.

The controller has two states:

- **ST_IDLE** accepts a request. From there, transition IDLE→READ_WAIT is taken for an in-window read. All other requests stay in IDLE and respond on the next cycle.
- **ST_READ_WAIT** waits one cycle for the memory data. It then returns through transition READ_WAIT→IDLE, registering the response and, for planar reads, the latch.

Top module: `vmem_plane_unit`

## Requirements
- R1: The map mode selects the window. Mode 0 accepts every offset as is. Mode 1 accepts offsets below 0x10000. Mode 2 accepts 0x10000..0x17FFF and subtracts 0x10000. Mode 3 accepts 0x18000..0x1FFFF and subtracts 0x18000. An out-of-window read returns 0xFF, issues no memory access and leaves the latch unchanged. An out-of-window write changes no memory.
- R2: With chain-4 enabled, which overrides odd/even, offset o selects word o>>2 and plane o[1:0]. A write stores the host byte in that plane only, and only if map_mask bit [plane] is 1. A read returns that byte.
- R3: With odd/even enabled and chain-4 off, the plane is {plane_sel[1], o[0]} and the word is o>>1. Writes are gated by the map mask, and reads return that plane's byte.
- R4: A planar read loads the whole addressed word into the latch. With read_mode 0, it returns the byte of plane plane_sel.
- R5: With read_mode 1, result bit b is 1 when every plane p with cmp_care[p]=1 has its bit b equal to cmp_val[p].
- R6: Write mode 0 rotates the host byte right by rot_cnt and places it in every plane. Each plane with sr_en[p]=1 is instead filled with sr_val[p]. The ALU and bit mask then apply.
- R7: Write mode 1 stores the latch unchanged, ignoring the ALU and bit mask, and still honours the map mask.
- R8: Write mode 2 fills plane p with host bit p, then applies the ALU and bit mask.
- R9: Write mode 3 fills plane p with sr_val[p], and uses bit_mask ANDed with the rotated host byte as the bit mask.
- R10: The ALU function is applied to the data with the latch: code 0 passes the data, 1 ANDs, 2 ORs and 3 XORs.
- R11: Each data bit whose bit-mask position is 1 comes from the ALU result, and every other bit comes from the latch. Only planes with map_mask[p]=1 are written.
- R12: Responses are timed as follows:
  - A write or an out-of-window access raises rsp_valid for one cycle, one cycle after acceptance.
  - An in-window read raises rsp_valid two cycles after acceptance, and req_ready is low in between.
  - The memory never sees a read and a write in the same cycle.
- R13: After reset, rsp_valid is 0, req_ready is 1 and the latch is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte offset within the 128 KiB window |
| req_wdata | input | 8 | Host write byte |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 8 | Read result |
| map_mode | input | 2 | Window select |
| chain4_en | input | 1 | Chain-4 addressing |
| odd_even_en | input | 1 | Odd/even addressing |
| plane_sel | input | 2 | Read plane / odd-even page |
| read_mode | input | 1 | 0 plane select, 1 colour compare |
| write_mode | input | 2 | Write mode 0..3 |
| rot_cnt | input | 3 | Right-rotate count |
| alu_fn | input | 2 | ALU function |
| sr_val | input | 4 | Set/reset value per plane |
| sr_en | input | 4 | Set/reset enable per plane |
| cmp_val | input | 4 | Compare colour per plane |
| cmp_care | input | 4 | Compare enable per plane |
| bit_mask | input | 8 | Bit mask |
| map_mask | input | 4 | Plane write enable |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Memory word index |
| mem_be | output | 4 | Per-plane byte enables |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid one cycle after mem_rd_en |

## Verification
The memory strobes are combinational in the acceptance cycle. Write results are therefore due in the memory one edge later. Out-of-window and write responses are due on that same edge, and in-window read data and the latch load follow one edge after that. The bench drives each request at a falling edge and samples rsp_valid, req_ready and rsp_rdata at the following falling edges. It checks the idle gap of a read as well as its result. After each write, it compares every memory word against a behavioural reference computed from the requirements.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
    localparam int NPLANE = 4;
    localparam int PW     = 8;
    localparam int WORD_W = NPLANE * PW;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_READ_WAIT
    } vm_state_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_AND  = 2'd1,
        ALU_OR   = 2'd2,
        ALU_XOR  = 2'd3
    } vm_alu_e;
endpackage

// File: rtl/vmem_addr_map.sv
module vmem_addr_map
    import vmem_pkg::*;
#(
    parameter int WIN_W = 17
) (
    input  logic [WIN_W-1:0] host_addr,
    input  logic [1:0]       map_mode,
    input  logic             chain4_en,
    input  logic             odd_even_en,
    input  logic [1:0]       plane_sel,
    output logic             hit,
    output logic [WIN_W-1:0] word_addr,
    output logic [1:0]       lane,
    output logic             planar
);
    localparam logic [WIN_W-1:0] BASE_HI  = WIN_W'(1) << (WIN_W - 1);
    localparam logic [WIN_W-1:0] BASE_TOP = BASE_HI + (BASE_HI >> 1);

    logic [WIN_W-1:0] off;

    // window decode: base subtraction and limit per map mode
    always_comb begin
        unique case (map_mode)
            2'd0: begin off = host_addr;            hit = 1'b1; end
            2'd1: begin off = host_addr;            hit = host_addr < BASE_HI; end
            2'd2: begin off = host_addr - BASE_HI;  hit = (host_addr >= BASE_HI) && (host_addr < BASE_TOP); end
            default: begin off = host_addr - BASE_TOP; hit = host_addr >= BASE_TOP; end
        endcase
    end

    // addressing scheme: chain-4 beats odd/even beats planar
    always_comb begin
        if (chain4_en) begin
            word_addr = off >> 2;
            lane      = off[1:0];
            planar    = 1'b0;
        end else if (odd_even_en) begin
            word_addr = off >> 1;
            lane      = {plane_sel[1], off[0]};
            planar    = 1'b0;
        end else begin
            word_addr = off;
            lane      = plane_sel;
            planar    = 1'b1;
        end
    end
endmodule

// File: rtl/vmem_write_path.sv
module vmem_write_path
    import vmem_pkg::*;
(
    input  logic [PW-1:0]     host_data,
    input  logic [WORD_W-1:0] latch,
    input  logic [1:0]        write_mode,
    input  logic [2:0]        rot_cnt,
    input  logic [1:0]        alu_fn,
    input  logic [NPLANE-1:0] sr_val,
    input  logic [NPLANE-1:0] sr_en,
    input  logic [PW-1:0]     bit_mask,
    output logic [WORD_W-1:0] wdata
);
    logic [PW-1:0] rot;

    always_comb begin
        for (int b = 0; b < PW; b++) begin
            rot[b] = host_data[(b + int'(rot_cnt)) % PW];
        end
    end

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [PW-1:0] lat_p, src_p, alu_p, msk_p;
        assign lat_p = latch[p*PW +: PW];

        // stage 1: source data and effective mask by write mode
        always_comb begin
            unique case (write_mode)
                2'd0: begin src_p = sr_en[p] ? {PW{sr_val[p]}} : rot; msk_p = bit_mask; end
                2'd1: begin src_p = lat_p;                      msk_p = '1; end
                2'd2: begin src_p = {PW{host_data[p]}};         msk_p = bit_mask; end
                default: begin src_p = {PW{sr_val[p]}};         msk_p = bit_mask & rot; end
            endcase
        end

        // stage 2: ALU against the latch (bypassed in mode 1)
        always_comb begin
            if (write_mode == 2'd1) begin
                alu_p = src_p;
            end else begin
                unique case (vm_alu_e'(alu_fn))
                    ALU_PASS: alu_p = src_p;
                    ALU_AND:  alu_p = src_p & lat_p;
                    ALU_OR:   alu_p = src_p | lat_p;
                    ALU_XOR:  alu_p = src_p ^ lat_p;
                endcase
            end
        end

        // stage 3: bit-mask merge with the latch
        assign wdata[p*PW +: PW] = (alu_p & msk_p) | (lat_p & ~msk_p);
    end
endmodule

// File: rtl/vmem_read_path.sv
module vmem_read_path
    import vmem_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              read_mode,
    input  logic [1:0]        plane_sel,
    input  logic [NPLANE-1:0] cmp_val,
    input  logic [NPLANE-1:0] cmp_care,
    output logic [PW-1:0]     rdata
);
    logic [PW-1:0] match;

    for (genvar b = 0; b < PW; b++) begin : g_bit
        logic [NPLANE-1:0] col;
        for (genvar p = 0; p < NPLANE; p++) begin : g_pl
            assign col[p] = word[p*PW + b];
        end
        assign match[b] = &(~cmp_care | ~(col ^ cmp_val));
    end

    assign rdata = read_mode ? match : word[plane_sel*PW +: PW];
endmodule

// File: rtl/vmem_plane_unit.sv
module vmem_plane_unit
    import vmem_pkg::*;
#(
    parameter int WIN_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WIN_W-1:0]  req_addr,
    input  logic [PW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PW-1:0]     rsp_rdata,
    input  logic [1:0]        map_mode,
    input  logic              chain4_en,
    input  logic              odd_even_en,
    input  logic [1:0]        plane_sel,
    input  logic              read_mode,
    input  logic [1:0]        write_mode,
    input  logic [2:0]        rot_cnt,
    input  logic [1:0]        alu_fn,
    input  logic [NPLANE-1:0] sr_val,
    input  logic [NPLANE-1:0] sr_en,
    input  logic [NPLANE-1:0] cmp_val,
    input  logic [NPLANE-1:0] cmp_care,
    input  logic [PW-1:0]     bit_mask,
    input  logic [NPLANE-1:0] map_mask,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [WIN_W-1:0]  mem_addr,
    output logic [NPLANE-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    vm_state_e         state_q, state_d;
    logic [WORD_W-1:0] latch_q;
    logic [1:0]        lane_q;
    logic              planar_q;

    logic              am_hit, am_planar;
    logic [WIN_W-1:0]  am_word;
    logic [1:0]        am_lane;
    logic [WORD_W-1:0] wp_data;
    logic [PW-1:0]     rp_data;
    logic [NPLANE-1:0] lane_oh;
    logic              accept;

    vmem_addr_map #(.WIN_W(WIN_W)) u_map (
        .host_addr   (req_addr),
        .map_mode    (map_mode),
        .chain4_en   (chain4_en),
        .odd_even_en (odd_even_en),
        .plane_sel   (plane_sel),
        .hit         (am_hit),
        .word_addr   (am_word),
        .lane        (am_lane),
        .planar      (am_planar)
    );

    vmem_write_path u_wr (
        .host_data  (req_wdata),
        .latch      (latch_q),
        .write_mode (write_mode),
        .rot_cnt    (rot_cnt),
        .alu_fn     (alu_fn),
        .sr_val     (sr_val),
        .sr_en      (sr_en),
        .bit_mask   (bit_mask),
        .wdata      (wp_data)
    );

    vmem_read_path u_rd (
        .word      (mem_rdata),
        .read_mode (read_mode),
        .plane_sel (plane_sel),
        .cmp_val   (cmp_val),
        .cmp_care  (cmp_care),
        .rdata     (rp_data)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        lane_oh          = '0;
        lane_oh[am_lane] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and memory-side outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_be    = '0;
        mem_addr  = am_word;
        mem_wdata = am_planar ? wp_data : {NPLANE{req_wdata}};
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && am_hit) begin
                    if (req_write) begin
                        mem_wr_en = 1'b1;
                        mem_be    = am_planar ? map_mask : (lane_oh & map_mask);
                    end else begin
                        mem_rd_en = 1'b1;
                        state_d   = ST_READ_WAIT;   // IDLE->READ_WAIT
                    end
                end
            end
            ST_READ_WAIT: state_d = ST_IDLE;        // READ_WAIT->IDLE
        endcase
    end

    // response and latch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            latch_q   <= '0;
            lane_q    <= '0;
            planar_q  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                lane_q   <= am_lane;
                planar_q <= am_planar;
                if (req_write || !am_hit) rsp_valid <= 1'b1;
                if (!req_write && !am_hit) rsp_rdata <= '1;
            end
            if (state_q == ST_READ_WAIT) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= planar_q ? rp_data : mem_rdata[lane_q*PW +: PW];
                if (planar_q) latch_q <= mem_rdata;
            end
        end
    end

    assert_no_rdwr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    assert_read_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_WAIT) |=> rsp_valid);
    assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !am_hit) |-> (!mem_rd_en && !mem_wr_en));
    assert_plane_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_be & ~map_mask) == '0));
    assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !am_planar) |-> ($countones(mem_be) <= 1));
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ_WAIT) |=> $stable(latch_q));
endmodule

// File: tb/vmem_plane_unit_tb.sv
module vmem_plane_unit_tb;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [1:0]  c_map = 0, c_psel = 0, c_wmode = 0, c_alu = 0;
    logic        c_c4 = 0, c_oe = 0, c_rmode = 0;
    logic [2:0]  c_rot = 0;
    logic [3:0]  c_srval = 0, c_sren = 0, c_cmp = 0, c_care = 0, c_mm = 4'hF;
    logic [7:0]  c_bm = 8'hFF;
    logic        mem_rd_en, mem_wr_en;
    logic [16:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_vec = 0, n_bad = 0;

    logic [31:0] mem     [int];
    logic [31:0] ref_mem [int];
    logic [31:0] ref_latch = '0;

    vmem_plane_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .map_mode(c_map), .chain4_en(c_c4), .odd_even_en(c_oe),
        .plane_sel(c_psel), .read_mode(c_rmode), .write_mode(c_wmode),
        .rot_cnt(c_rot), .alu_fn(c_alu), .sr_val(c_srval), .sr_en(c_sren),
        .cmp_val(c_cmp), .cmp_care(c_care), .bit_mask(c_bm), .map_mask(c_mm),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] rd_mem(input int k);
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction
    function automatic logic [31:0] rd_ref(input int k);
        return ref_mem.exists(k) ? ref_mem[k] : 32'h0;
    endfunction

    // memory with one-cycle read latency and byte enables
    always @(posedge clk) begin
        if (mem_wr_en && mem_be != 0) begin
            logic [31:0] t;
            t = rd_mem(int'(mem_addr));
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) t[b*8 +: 8] = mem_wdata[b*8 +: 8];
            mem[int'(mem_addr)] = t;
        end
        if (mem_rd_en) mem_rdata <= rd_mem(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for one host access
    task automatic model_access(input bit wr, input int a, input logic [7:0] h,
                                output bit hit, output logic [7:0] rd);
        int off, w, pl;
        bit planar;
        logic [31:0] word, nw;
        logic [7:0] rot;
        rd = 8'hFF;
        case (c_map)
            2'd0: begin off = a; hit = 1; end
            2'd1: begin off = a; hit = (a < 'h10000); end
            2'd2: begin off = a - 'h10000; hit = (a >= 'h10000) && (a < 'h18000); end
            default: begin off = a - 'h18000; hit = (a >= 'h18000); end
        endcase
        if (!hit) return;
        planar = 0;
        if (c_c4) begin w = off / 4; pl = off % 4; end
        else if (c_oe) begin pl = (int'(c_psel) & 2) | (off & 1); w = (((off & ~1) * 2) | pl) / 4; end
        else begin w = off; pl = int'(c_psel); planar = 1; end
        word = rd_ref(w);
        if (!wr) begin
            if (!planar) rd = word[pl*8 +: 8];
            else begin
                ref_latch = word;
                if (!c_rmode) rd = word[pl*8 +: 8];
                else for (int b = 0; b < 8; b++) begin
                    bit ok = 1;
                    for (int p = 0; p < 4; p++)
                        if (c_care[p] && word[p*8+b] != c_cmp[p]) ok = 0;
                    rd[b] = ok;
                end
            end
            return;
        end
        if (!planar) begin
            if (c_mm[pl]) begin word[pl*8 +: 8] = h; ref_mem[w] = word; end
            return;
        end
        for (int b = 0; b < 8; b++) rot[b] = h[(b + int'(c_rot)) % 8];
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                bit lb, db, mb;
                lb = ref_latch[p*8+b];
                case (c_wmode)
                    2'd0: begin db = c_sren[p] ? c_srval[p] : rot[b]; mb = c_bm[b]; end
                    2'd1: begin db = lb; mb = 1; end
                    2'd2: begin db = h[p]; mb = c_bm[b]; end
                    default: begin db = c_srval[p]; mb = c_bm[b] & rot[b]; end
                endcase
                if (c_wmode != 2'd1) begin
                    if (c_alu == 1) db = db & lb;
                    else if (c_alu == 2) db = db | lb;
                    else if (c_alu == 3) db = db ^ lb;
                end
                nw[p*8+b] = mb ? db : lb;
            end
        end
        for (int p = 0; p < 4; p++)
            if (c_mm[p]) word[p*8 +: 8] = nw[p*8 +: 8];
        if (c_mm != 0) ref_mem[w] = word;
    endtask

    task automatic compare_mem(input string tag);
        foreach (ref_mem[k]) chk(rd_mem(k) === ref_mem[k], tag, "memory word", rd_mem(k), ref_mem[k]);
        foreach (mem[k]) if (!ref_mem.exists(k)) chk(mem[k] === 32'h0, tag, "stray memory word", mem[k], 0);
    endtask

    task automatic access(input bit wr, input int a, input logic [7:0] h, input string tag);
        bit hit;
        logic [7:0] exp_rd;
        model_access(wr, a, h, hit, exp_rd);
        @(negedge clk);
        chk(req_ready === 1'b1, "R12", "ready while idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_addr = 17'(a); req_wdata = h;
        @(negedge clk);
        req_valid = 0;
        if (wr || !hit) begin
            chk(rsp_valid === 1'b1, "R12", "single-cycle response", rsp_valid, 1);
            if (!wr) chk(rsp_rdata === exp_rd, tag, "miss read data", rsp_rdata, exp_rd);
        end else begin
            chk(rsp_valid === 1'b0 && req_ready === 1'b0, "R12", "read gap", {rsp_valid, req_ready}, 0);
            @(negedge clk);
            chk(rsp_valid === 1'b1, "R12", "read response", rsp_valid, 1);
            chk(rsp_rdata === exp_rd, tag, "read data", rsp_rdata, exp_rd);
        end
        if (wr) compare_mem(tag);
    endtask

    initial begin
        #(CLK_NS * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R13", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R13", "idle after reset", {req_ready, rsp_valid}, 2);

        // R13: latch starts at zero, seen through write mode 1
        c_wmode = 1; c_mm = 4'hF;
        access(1, 100, 8'h00, "R13");

        // R2: chain-4 fill of words 0..7
        c_c4 = 1; c_map = 0;
        for (int k = 0; k < 32; k++) access(1, k, 8'((k * 37 + 11) & 255), "R2");
        c_mm = 4'b0101;
        access(1, 33, 8'hAA, "R2");
        access(1, 34, 8'h55, "R2");
        c_mm = 4'hF;
        access(0, 21, 8'h00, "R2");
        access(0, 34, 8'h00, "R2");

        // R3: odd/even
        c_c4 = 0; c_oe = 1; c_psel = 2;
        access(1, 7, 8'hC3, "R3");
        access(0, 6, 8'h00, "R3");
        access(0, 7, 8'h00, "R3");
        c_psel = 0; c_mm = 4'b1110;
        access(1, 9, 8'h3C, "R3");
        access(1, 8, 8'h77, "R3");
        c_mm = 4'hF;

        // R4: planar read mode 0
        c_oe = 0; c_rmode = 0;
        for (int p = 0; p < 4; p++) begin c_psel = 2'(p); access(0, 5, 8'h00, "R4"); end

        // R5: colour compare
        c_rmode = 1;
        c_cmp = 4'b1010; c_care = 4'b1111; access(0, 2, 8'h00, "R5");
        c_care = 4'b0001; access(0, 3, 8'h00, "R5");
        c_care = 4'b0000; access(0, 4, 8'h00, "R5");
        c_cmp = 4'b0110; c_care = 4'b0110; access(0, 6, 8'h00, "R5");
        c_rmode = 0; c_psel = 0;

        // R6: write mode 0 with rotate and set/reset
        c_wmode = 0; c_alu = 0;
        access(0, 1, 8'h00, "R4");
        c_rot = 3; c_sren = 4'b0101; c_srval = 4'b0100; c_bm = 8'hF0;
        access(1, 9, 8'h96, "R6");
        c_rot = 0; c_sren = 0; c_bm = 8'hFF;
        access(1, 10, 8'h5A, "R6");

        // R10: ALU functions
        for (int f = 1; f < 4; f++) begin
            c_alu = 2'(f);
            access(0, f, 8'h00, "R4");
            access(1, 20 + f, 8'hC6, "R10");
        end
        c_alu = 0;

        // R7: write mode 1 copies latch, ignoring ALU and mask
        access(0, 4, 8'h00, "R4");
        c_wmode = 1; c_alu = 3; c_bm = 8'h00; c_mm = 4'b1011;
        access(1, 12, 8'hFF, "R7");
        c_alu = 0; c_bm = 8'hFF; c_mm = 4'hF;

        // R8: write mode 2
        c_wmode = 2; c_bm = 8'h3C;
        access(0, 6, 8'h00, "R4");
        access(1, 13, 8'hF9, "R8");
        c_alu = 2; access(1, 14, 8'h06, "R8");
        c_alu = 0;

        // R9: write mode 3
        c_wmode = 3; c_srval = 4'b1001; c_rot = 2; c_bm = 8'hEE;
        access(0, 7, 8'h00, "R4");
        access(1, 15, 8'hB4, "R9");
        c_rot = 0;

        // R11: zero bit mask keeps latch; partial map mask
        c_wmode = 0; c_bm = 8'h00; c_mm = 4'b0110;
        access(1, 16, 8'h12, "R11");
        c_bm = 8'h81; c_mm = 4'b1001;
        access(1, 17, 8'hE7, "R11");
        c_bm = 8'hFF; c_mm = 4'hF;

        // R1: window decode
        c_map = 1;
        access(0, 'h10004, 8'h00, "R1");
        access(1, 'h12000, 8'h44, "R1");
        access(0, 'h00005, 8'h00, "R1");
        c_map = 2;
        access(0, 'h08000, 8'h00, "R1");
        access(0, 'h18000, 8'h00, "R1");
        access(0, 'h10005, 8'h00, "R1");
        c_wmode = 0; access(1, 'h10018, 8'h21, "R1");
        c_map = 3;
        access(0, 'h17FFF, 8'h00, "R1");
        access(1, 'h00003, 8'h99, "R1");
        access(0, 'h18003, 8'h00, "R1");
        // latch survives an out-of-window read
        access(0, 'h00010, 8'h00, "R1");
        c_wmode = 1;
        access(1, 'h18019, 8'h00, "R1");
        c_map = 0; c_wmode = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule